// File: doc/BRIEF.md
# E1 Backplane Timeslot Interleaver

The block joins four 2.048 Mbit/s E1 line streams, one per framer link, into a single 8.192 Mbit/s backplane stream. It also splits a 8.192 Mbit/s backplane stream back into four line streams. Everything runs on one 8.192 MHz clock. One line bit lasts four fast clocks, and one backplane bit lasts one fast clock. A frame is 256 line bits, which makes 1024 fast clocks.

A frame counter provides the timing. A frame pulse aligns it, and it reports where the current line timeslot falls in the frame. From the counter the block derives a strobe for the alignment timeslot, a strobe for the signaling slot or slots, and the payload channel number of the current timeslot. On the backplane, each timeslot is spread over four consecutive 8-bit channels, one per link, in link order. Channel number is 4 × timeslot + link. In both directions every byte is sent most significant bit first, with no bit reversal. Both paths delay the data by exactly one timeslot (32 fast clocks).

Top module: `e1_bp_interleaver`

## Requirements
- R1: The frame position p counts 0..1023 and wraps to 0. When `fp_i` is high at a clock edge, p is 0 in the following cycle. The current timeslot is p/32. The line bit within the slot is (p mod 32)/4. The backplane link is (p mod 32)/8, and the backplane bit is p mod 8.
- R2: `slip_o` is low after reset. It goes high when a frame pulse arrives while p ≠ 1023 and an earlier pulse has already been seen since reset. The first pulse after reset never sets it. Once high, it stays high until reset.
- R3: `ts0_o` is high for exactly the 32 cycles of timeslot 0 (p = 0..31).
- R4: With `ccs_i` low, `sig_o` is high only during timeslot 16. With `ccs_i` high, it is high during timeslots 15, 16 and 31.
- R5: `chan_o` gives the payload channel number. Timeslots 1..15 give 1..15, timeslots 17..31 give 16..30, and timeslots 0 and 16 give 0. `ccs_i` does not change it.
- R6: Each `line_i[l]` is sampled once per line bit, at the cycle where p mod 4 = 2. Values present in the other three cycles have no effect on `bp_o`.
- R7: The 8 bits that link l sends during timeslot N appear on `bp_o` during timeslot N+1, at cycles p mod 32 = 8l .. 8l+7. The first-received bit comes first. Timeslot 31 comes out in timeslot 0 of the next frame.
- R8: `bp_i` is sampled every cycle. The 8 bits at p mod 32 = 8l .. 8l+7 of timeslot N form link l's byte. That byte is sent on `line_o[l]` during timeslot N+1, MSB first, one bit per four cycles.
- R9: `line_o` changes only in cycles where p mod 4 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 8.192 MHz fast clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fp_i | input | 1 | Frame pulse; the next cycle is position 0 |
| ccs_i | input | 1 | Common-channel mode: signaling strobe also covers timeslots 15 and 31 |
| line_i | input | 4 | Four 2.048 Mbit/s line inputs, bit l = link l |
| bp_i | input | 1 | 8.192 Mbit/s backplane input |
| bp_o | output | 1 | 8.192 Mbit/s merged backplane output |
| line_o | output | 4 | Four 2.048 Mbit/s split line outputs |
| ts0_o | output | 1 | Timeslot 0 strobe |
| sig_o | output | 1 | Signaling timeslot strobe |
| chan_o | output | 5 | Payload channel number, 0 for reserved slots |
| slip_o | output | 1 | Sticky frame-slip flag |

## Verification
A frame pulse can force a realignment in the same cycle that the capture registers of both paths are handed over to their output holds. Both happen when the pulse lands on the last clock of a timeslot (position 511). The bench provokes this with a pulse at exactly that position. It then checks `bp_o` and `line_o` in the following slot against bytes that its model collected up to that edge, while the counter restarts from 0. The bench drives different line values in every fast cycle. Sampling at any phase other than the mid-bit one would therefore corrupt the merged stream.

// File: rtl/e1il_pkg.sv
package e1il_pkg;

  // Payload channel number of a timeslot: the alignment slot and the
  // signaling slot carry none, later slots close the gap left by the
  // signaling slot.
  function automatic int payload_chan(input int ts, input int sig_ts);
    if (ts == 0 || ts == sig_ts) return 0;
    else if (ts < sig_ts)        return ts;
    else                         return ts - 1;
  endfunction

endpackage

// File: rtl/e1il_frame_ctr.sv
module e1il_frame_ctr #(
  parameter int FRAME_CLKS = 1024,
  parameter int N_SLOT     = 32,
  parameter int SIG_TS     = 16,
  parameter int CCS_LO     = 15,
  parameter int CCS_HI     = 31,
  localparam int CNT_W     = $clog2(FRAME_CLKS),
  localparam int TS_W      = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_i,
  input  logic             ccs_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ts0_o,
  output logic             sig_o,
  output logic [TS_W-1:0]  chan_o,
  output logic             slip_o
);
  import e1il_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CLKS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             slip_q, slip_d;
  logic             at_end;
  logic [TS_W-1:0]  ts;

  always_comb begin
    at_end = (cnt_q == LAST);
    if (fp_i || at_end) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
    seen_d = seen_q | fp_i;
    slip_d = slip_q | (fp_i & seen_q & ~at_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      slip_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
      slip_q <= slip_d;
    end
  end

  always_comb begin
    ts     = cnt_q[CNT_W-1 -: TS_W];
    ts0_o  = (ts == '0);
    sig_o  = (ts == TS_W'(SIG_TS)) ||
             (ccs_i && (ts == TS_W'(CCS_LO) || ts == TS_W'(CCS_HI)));
    chan_o = TS_W'(payload_chan(int'(ts), SIG_TS));
  end

  assign cnt_o  = cnt_q;
  assign slip_o = slip_q;

  assert_realign_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fp_i |=> (cnt_q == '0));
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));
  assert_slip_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slip_q |=> slip_q);
  assert_slip_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slip_q) |-> $past(fp_i && seen_q));
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ts0_o && sig_o));
  assert_chan_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ts0_o |-> (chan_o == '0));
endmodule

// File: rtl/e1il_mux.sv
module e1il_mux #(
  parameter int N_LINK    = 4,
  parameter int SLOT_BITS = 8,
  localparam int LK_W     = $clog2(N_LINK),
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int POS_W    = LK_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [N_LINK-1:0] line_i,
  output logic              bp_o
);
  localparam logic [LK_W-1:0]  MID_PH  = LK_W'(N_LINK / 2);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(SLOT_BITS - 1);

  logic [N_LINK-1:0][SLOT_BITS-1:0] cap_q, cap_d;
  logic [N_LINK-1:0][SLOT_BITS-1:0] hold_q, hold_d;
  logic sample_en, xfer_en;

  always_comb begin
    sample_en = (pos_i[LK_W-1:0] == MID_PH);
    xfer_en   = (pos_i == '1);
  end

  for (genvar l = 0; l < N_LINK; l++) begin : g_link
    always_comb begin
      cap_d[l]  = sample_en ? {cap_q[l][SLOT_BITS-2:0], line_i[l]} : cap_q[l];
      hold_d[l] = xfer_en ? cap_q[l] : hold_q[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      hold_q <= '0;
    end else begin
      cap_q  <= cap_d;
      hold_q <= hold_d;
    end
  end

  assign bp_o = hold_q[pos_i[POS_W-1 -: LK_W]][BIT_MAX - pos_i[BIT_W-1:0]];

  assert_hold_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i != '1) |=> $stable(hold_q));
  assert_cap_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i[LK_W-1:0] != MID_PH) |=> $stable(cap_q));
endmodule

// File: rtl/e1il_demux.sv
module e1il_demux #(
  parameter int N_LINK    = 4,
  parameter int SLOT_BITS = 8,
  localparam int LK_W     = $clog2(N_LINK),
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int POS_W    = LK_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              bp_i,
  output logic [N_LINK-1:0] line_o
);
  localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(SLOT_BITS - 1);

  logic [N_LINK-1:0][SLOT_BITS-1:0] dcap_q, dcap_d;
  logic [N_LINK-1:0][SLOT_BITS-1:0] dhold_q, dhold_d;
  logic [LK_W-1:0]  wr_link;
  logic [BIT_W-1:0] wr_bit;
  logic [BIT_W-1:0] rd_bit;

  always_comb begin
    wr_link = pos_i[POS_W-1 -: LK_W];
    wr_bit  = BIT_MAX - pos_i[BIT_W-1:0];
    rd_bit  = BIT_MAX - pos_i[POS_W-1 -: BIT_W];
    dcap_d  = dcap_q;
    dcap_d[wr_link][wr_bit] = bp_i;
    dhold_d = (pos_i == '1) ? dcap_d : dhold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcap_q  <= '0;
      dhold_q <= '0;
    end else begin
      dcap_q  <= dcap_d;
      dhold_q <= dhold_d;
    end
  end

  for (genvar l = 0; l < N_LINK; l++) begin : g_out
    assign line_o[l] = dhold_q[l][rd_bit];
  end

  assert_line_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i[LK_W-1:0] != '0) |-> $stable(line_o));
  assert_dhold_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i != '1) |=> $stable(dhold_q));
endmodule

// File: rtl/e1_bp_interleaver.sv
module e1_bp_interleaver #(
  parameter int N_LINK    = 4,
  parameter int SLOT_BITS = 8,
  parameter int N_SLOT    = 32,
  parameter int SIG_TS    = 16,
  parameter int CCS_LO    = 15,
  parameter int CCS_HI    = 31,
  localparam int TS_W     = $clog2(N_SLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fp_i,
  input  logic              ccs_i,
  input  logic [N_LINK-1:0] line_i,
  input  logic              bp_i,
  output logic              bp_o,
  output logic [N_LINK-1:0] line_o,
  output logic              ts0_o,
  output logic              sig_o,
  output logic [TS_W-1:0]   chan_o,
  output logic              slip_o
);
  localparam int FRAME_CLKS = N_SLOT * SLOT_BITS * N_LINK;
  localparam int CNT_W      = $clog2(FRAME_CLKS);
  localparam int POS_W      = $clog2(N_LINK) + $clog2(SLOT_BITS);

  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] pos;

  e1il_frame_ctr #(
    .FRAME_CLKS(FRAME_CLKS), .N_SLOT(N_SLOT), .SIG_TS(SIG_TS),
    .CCS_LO(CCS_LO), .CCS_HI(CCS_HI)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .ccs_i(ccs_i),
    .cnt_o(cnt), .ts0_o(ts0_o), .sig_o(sig_o), .chan_o(chan_o),
    .slip_o(slip_o)
  );

  assign pos = cnt[POS_W-1:0];

  e1il_mux #(.N_LINK(N_LINK), .SLOT_BITS(SLOT_BITS)) u_mux (
    .clk(clk), .rst_n(rst_n), .pos_i(pos), .line_i(line_i), .bp_o(bp_o)
  );

  e1il_demux #(.N_LINK(N_LINK), .SLOT_BITS(SLOT_BITS)) u_demux (
    .clk(clk), .rst_n(rst_n), .pos_i(pos), .bp_i(bp_i), .line_o(line_o)
  );

  assert_sig_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_o && !ccs_i) |-> (chan_o == '0));
endmodule

// File: tb/e1_bp_interleaver_tb_top.sv
module e1_bp_interleaver_tb_top;
  logic clk;
  logic rst_n, fp_i, ccs_i, bp_i;
  logic [3:0] line_i;
  logic bp_o, ts0_o, sig_o, slip_o;
  logic [3:0] line_o;
  logic [4:0] chan_o;

  int n_cmp, n_bad;
  int mcnt;
  bit mseen, mslip;
  logic [7:0] mcap[4], mhold[4], dcap[4], dhold[4];
  logic [3:0] prev_line;
  bit done;

  e1_bp_interleaver dut_i (
    .clk(clk), .rst_n(rst_n), .fp_i(fp_i), .ccs_i(ccs_i), .line_i(line_i),
    .bp_i(bp_i), .bp_o(bp_o), .line_o(line_o), .ts0_o(ts0_o), .sig_o(sig_o),
    .chan_o(chan_o), .slip_o(slip_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h pos=%0d t=%0t", tag, act, exp, mcnt, $time);
    end
  endtask

  task automatic compare_all();
    int ts, pos, ech;
    bit esig;
    logic [3:0] eline;
    ts  = mcnt / 32;
    pos = mcnt % 32;
    esig = (ts == 16) || (ccs_i && (ts == 15 || ts == 31));
    if (ts == 0 || ts == 16) ech = 0;
    else if (ts < 16)        ech = ts;
    else                     ech = ts - 1;
    for (int l = 0; l < 4; l++) eline[l] = dhold[l][7 - pos / 4];
    chk("R3 ts0 strobe", ts0_o, (ts == 0));
    chk("R4 signaling strobe", sig_o, esig);
    chk("R5 channel number", chan_o, ech);
    chk("R2 slip flag", slip_o, mslip);
    chk("R7 merged bit (R6 mid-bit sampling)", bp_o, mhold[pos / 8][7 - pos % 8]);
    chk("R8 split outputs", line_o, eline);
    if (mcnt % 4 != 0) chk("R9 line output steady", line_o, prev_line);
    prev_line = line_o;
  endtask

  task automatic step(input bit fp);
    logic [3:0] li;
    logic bi;
    int pos;
    li = 4'($urandom);
    bi = 1'($urandom);
    fp_i = fp; line_i = li; bp_i = bi;
    pos = mcnt % 32;
    if (mcnt % 4 == 2)
      for (int l = 0; l < 4; l++) mcap[l] = {mcap[l][6:0], li[l]};
    if (pos == 31) for (int l = 0; l < 4; l++) mhold[l] = mcap[l];
    dcap[pos / 8][7 - pos % 8] = bi;
    if (pos == 31) for (int l = 0; l < 4; l++) dhold[l] = dcap[l];
    if (fp) begin
      if (mseen && mcnt != 1023) mslip = 1'b1;
      mseen = 1'b1;
      mcnt = 0;
    end else begin
      mcnt = (mcnt + 1) % 1024;
    end
    @(negedge clk);
    if (fp) chk("R1 frame restart after pulse", {ts0_o, chan_o}, {1'b1, 5'd0});
    compare_all();
  endtask

  task automatic run(input int n, input int fp_pos);
    for (int i = 0; i < n; i++) step(mcnt == fp_pos);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; fp_i = 1'b0; ccs_i = 1'b0; line_i = '0; bp_i = 1'b0;
    mcnt = 0; mseen = 1'b0; mslip = 1'b0;
    for (int l = 0; l < 4; l++) begin
      mcap[l] = '0; mhold[l] = '0; dcap[l] = '0; dhold[l] = '0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    prev_line = line_o;
    compare_all();                 // reset state, all requirements at p = 0
    run(1100, -1);                 // R1 free-running wrap without pulses
    run(600, 500);                 // first pulse, misplaced: no slip (R2)
    run(3000, 1023);               // aligned pulses
    ccs_i = 1'b1;
    run(1100, 1023);               // R4 common-channel mode
    ccs_i = 1'b0;
    run(400, 300);                 // misplaced pulse sets slip (R2)
    run(2100, 1023);               // slip stays set
    run(600, 511);                 // pulse on the slot hand-over cycle
    run(1100, 1023);
    finish_run();
  end
endmodule